// File: doc/BRIEF.md
# Frame-Synchronized Serial Receiver with Error Flags

This block is the receive half of a synchronous serial port. A single-cycle frame-sync pulse marks the start of each word. The data input is then sampled on the next `WIDTH` rising clock edges, most significant bit first. Each completed word passes through a one-word hold stage into a one-word receive buffer. A CPU or DMA agent drains the buffer with a read strobe.

The serial side has no back-pressure. Words keep arriving whether or not the buffer has been read. When both the hold stage and the buffer are occupied, the buffer keeps its word and each newly finished word replaces the contents of the hold stage. On the read side, `rd_valid` marks a buffered word. A pulse on `rd_stb` while `rd_valid` is high consumes that word. A pulse while `rd_valid` is low is an error, not a transfer.

Three error events raise sticky flags: overrun, a frame sync that arrives mid-word, and a read from an empty buffer. Writing ones clears the flags. An interrupt output combines the flags with per-flag enables. A separate receive-full indication mirrors the overrun condition until the buffer is next read.

Top module: `rxerr_rx`

## Requirements
- R1: After reset, `rd_valid`, `rx_full`, `irq` and all three bits of `flags` are 0.
- R2: While idle, a high `fsync` at a rising edge starts a word. The following `WIDTH` rising edges sample `sdata`, and the first sampled bit becomes the word's MSB.
- R3: If the hold stage and buffer are empty, `rd_valid` rises, with the word on `rd_data`, one clock after the edge that samples the word's last bit. It is still low immediately after that edge.
- R4: A read (`rd_stb` high with `rd_valid` high) drops `rd_valid` at that edge. A word waiting in the hold stage moves into the buffer on the next edge.
- R5: A buffered word stays on `rd_data` unchanged until it is read.
- R6: If a word completes while both the buffer and the hold stage are full, it is an overrun. `flags[0]` is set, the new word replaces the hold stage and the buffered word is kept.
- R7: Under overrun, every further completed word replaces the hold stage until the buffer is read. After the read, the most recent word is the one delivered.
- R8: `rx_full` is set on an overrun and cleared by a read. If both happen in the same cycle, set wins.
- R9: A high `fsync` while a word is in progress, before its last bit, is ignored. The word completes unchanged and `flags[1]` is set.
- R10: A high `fsync` on the edge that samples a word's last bit starts the next word back-to-back, with no gap, and sets no flag.
- R11: `rd_stb` while `rd_valid` is low sets `flags[2]` and changes no data state.
- R12: Flags are sticky. `clr_stb` clears each flag whose `clr_mask` bit is 1. A flag being set in the same cycle stays set.
- R13: `irq` is high exactly when some flag is set whose `irq_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, all logic on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data input |
| fsync | input | 1 | Frame-sync pulse, one clock before the first bit |
| rd_stb | input | 1 | Read strobe from CPU/DMA side |
| rd_valid | output | 1 | Receive buffer holds a word |
| rd_data | output | WIDTH | Buffered word |
| clr_stb | input | 1 | Write strobe for flag clearing |
| clr_mask | input | 3 | Write-one-to-clear mask, bit order as `flags` |
| irq_en | input | 3 | Per-flag interrupt enables, bit order as `flags` |
| flags | output | 3 | Sticky flags: [0] overrun, [1] sync error, [2] underflow |
| rx_full | output | 1 | Receive-full indication tied to overrun |
| irq | output | 1 | Interrupt request |

## Verification
Directed words with distinct bit patterns (A5, 3C, 5A, 77, C3, 96, 69) show whether the bit order and latency are correct. They also show which word survives an overrun: the buffered word, the first hold-stage word or the latest arrival. Separate directed cases place frame syncs at an early bit and at the last bit, to tell an ignored pulse from a legitimate back-to-back start. A long random phase mixes sparse frame syncs, random data, read strobes and clear writes. That phase brings together reads with overruns and clears with sets, cases a directed sequence rarely reaches, and checks every cycle against a reference model.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NFLAG  = 3;
  localparam int F_OVR  = 0;
  localparam int F_SYNC = 1;
  localparam int F_UND  = 2;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxerr_deser.sv
module rxerr_deser #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             fsync,
  output logic             word_done,
  output logic [WIDTH-1:0] word,
  output logic             sync_err
);
  localparam int CW   = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam int LAST = WIDTH - 1;

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] shreg;
  logic             at_last;

  assign at_last   = busy && (cnt == CW'(LAST));
  assign word_done = at_last;
  assign word      = {shreg[WIDTH-2:0], sdata};
  assign sync_err  = busy && !at_last && fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (!busy) begin
      if (fsync) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      shreg <= {shreg[WIDTH-2:0], sdata};
      if (at_last) begin
        busy <= fsync;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fsync));

  // R9
  sync_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> busy);
endmodule

// File: rtl/rxerr_buf.sv
module rxerr_buf #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [WIDTH-1:0] word,
  input  logic             rd_stb,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             ovr_evt,
  output logic             und_evt,
  output logic             rx_full
);
  logic             hold_full, buf_full;
  logic [WIDTH-1:0] hold_q, buf_q;
  logic             rd_fire, move;

  assign rd_fire  = rd_stb && buf_full;
  assign und_evt  = rd_stb && !buf_full;
  assign move     = hold_full && !buf_full;
  assign ovr_evt  = done && hold_full && buf_full;
  assign rd_valid = buf_full;
  assign rd_data  = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      buf_full  <= 1'b0;
      hold_q    <= '0;
      buf_q     <= '0;
      rx_full   <= 1'b0;
    end else begin
      if (move) begin
        buf_q    <= hold_q;
        buf_full <= 1'b1;
      end else if (rd_fire) begin
        buf_full <= 1'b0;
      end
      if (done) begin
        hold_q    <= word;
        hold_full <= 1'b1;
      end else if (move) begin
        hold_full <= 1'b0;
      end
      if (ovr_evt)      rx_full <= 1'b1;
      else if (rd_fire) rx_full <= 1'b0;
    end
  end

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !rd_stb |=> buf_full && $stable(buf_q));

  // R4
  xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !buf_full |=> buf_full && (buf_q == $past(hold_q)));

  // R6
  ovr_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> hold_full && (hold_q == $past(word)));

  // R8
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> rx_full);
endmodule

// File: rtl/rxerr_flags.sv
module rxerr_flags
  import rxerr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      clr_stb,
  input  flag_vec_t clr_mask,
  input  flag_vec_t irq_en,
  output flag_vec_t flags,
  output logic      irq
);
  flag_vec_t clr_eff;

  assign clr_eff = clr_stb ? clr_mask : '0;
  assign irq     = |(flags & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_vec;
  end

  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R12
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((flags & $past(clr_mask & ~set_vec)) == '0));

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/rxerr_rx.sv
module rxerr_rx
  import rxerr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             fsync,
  input  logic             rd_stb,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             clr_stb,
  input  logic [2:0]       clr_mask,
  input  logic [2:0]       irq_en,
  output logic [2:0]       flags,
  output logic             irq,
  output logic             rx_full
);
  logic             done, sync_err, ovr_evt, und_evt;
  logic [WIDTH-1:0] word;
  flag_vec_t        set_vec;

  rxerr_deser #(.WIDTH(WIDTH)) u_deser (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .fsync(fsync),
    .word_done(done), .word(word), .sync_err(sync_err)
  );

  rxerr_buf #(.WIDTH(WIDTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .rd_stb(rd_stb),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovr_evt(ovr_evt),
    .und_evt(und_evt), .rx_full(rx_full)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[F_OVR]  = ovr_evt;
    set_vec[F_SYNC] = sync_err;
    set_vec[F_UND]  = und_evt;
  end

  rxerr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  // R11
  und_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !rd_valid |=> flags[F_UND]);
endmodule

// File: tb/tb_rxerr_rx.sv
`timescale 1ns/1ps
module tb_rxerr_rx;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, fsync = 1'b0, rd_stb = 1'b0, clr_stb = 1'b0;
  logic [2:0] clr_mask = '0, irq_en = '0;
  logic rd_valid, irq, rx_full;
  logic [W-1:0] rd_data;
  logic [2:0] flags;

  rxerr_rx #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .fsync(fsync), .rd_stb(rd_stb),
    .rd_valid(rd_valid), .rd_data(rd_data), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .irq_en(irq_en), .flags(flags), .irq(irq),
    .rx_full(rx_full)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  bit m_busy = 0, m_hfull = 0, m_bfull = 0, m_rxfull = 0;
  int m_cnt = 0;
  logic [W-1:0] m_sh = '0, m_hold = '0, m_buf = '0;
  logic [2:0] m_flags = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    bit done = m_busy && (m_cnt == W-1);
    logic [W-1:0] nw = {m_sh[W-2:0], sdata};
    bit se = m_busy && !done && fsync;
    bit fire = rd_stb && m_bfull;
    bit und = rd_stb && !m_bfull;
    bit mv = m_hfull && !m_bfull;
    bit ov = done && m_hfull && m_bfull;
    m_flags = (m_flags & ~(clr_stb ? clr_mask : 3'b000)) | {und, se, ov};
    if (ov) m_rxfull = 1;
    else if (fire) m_rxfull = 0;
    if (mv) begin m_buf = m_hold; m_bfull = 1; end
    else if (fire) m_bfull = 0;
    if (done) begin m_hold = nw; m_hfull = 1; end
    else if (mv) m_hfull = 0;
    if (!m_busy) begin
      if (fsync) begin m_busy = 1; m_cnt = 0; end
    end else begin
      m_sh = nw;
      if (done) begin m_busy = fsync; m_cnt = 0; end
      else m_cnt++;
    end
  endfunction

  function automatic bit exp_irq();
    return |(m_flags & irq_en);
  endfunction

  task automatic compare();
    chk(rd_valid == m_bfull, "R3 rd_valid", rd_valid, m_bfull);
    if (m_bfull) chk(rd_data == m_buf, "R6 rd_data", rd_data, m_buf);
    chk(flags[0] == m_flags[0], "R6 overrun flag", flags[0], m_flags[0]);
    chk(flags[1] == m_flags[1], "R9 sync flag", flags[1], m_flags[1]);
    chk(flags[2] == m_flags[2], "R11 underflow flag", flags[2], m_flags[2]);
    chk(rx_full == m_rxfull, "R8 rx_full", rx_full, m_rxfull);
    chk(irq == exp_irq(), "R13 irq", irq, exp_irq());
  endtask

  task automatic step(bit fs, bit sd, bit rs, bit cs, logic [2:0] cm);
    fsync = fs; sdata = sd; rd_stb = rs; clr_stb = cs; clr_mask = cm;
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 3'b000);
  endtask

  // glitch: bit index at which fsync is high (-1 none); start: emit fsync cycle
  task automatic send(logic [W-1:0] d, int glitch, bit start);
    if (start) step(1, 0, 0, 0, 3'b000);
    for (int i = 0; i < W; i++) step(i == glitch, d[W-1-i], 0, 0, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    chk(rx_full == 0, "R1 rx_full", rx_full, 0);
    chk(flags == 0, "R1 flags", flags, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 / R3 basic word and latency
    send(8'hA5, -1, 1);
    chk(rd_valid == 0, "R3 not yet valid", rd_valid, 0);
    idle();
    chk(rd_valid == 1, "R3 valid", rd_valid, 1);
    chk(rd_data == 8'hA5, "R2 MSB first", rd_data, 8'hA5);

    // R5 / R6 / R7 / R8 overrun sequence
    send(8'h3C, -1, 1); idle();
    chk(rd_data == 8'hA5, "R5 buffered word held", rd_data, 8'hA5);
    send(8'h5A, -1, 1);
    chk(flags[0] == 1, "R6 overrun flag", flags[0], 1);
    chk(rx_full == 1, "R8 rx_full set", rx_full, 1);
    chk(rd_data == 8'hA5, "R6 buffer kept", rd_data, 8'hA5);
    send(8'h77, -1, 1);
    step(0, 0, 1, 0, 3'b000);
    chk(rd_valid == 0, "R4 read drops valid", rd_valid, 0);
    chk(rx_full == 0, "R8 rx_full cleared", rx_full, 0);
    idle();
    chk(rd_valid == 1, "R4 hold moves in", rd_valid, 1);
    chk(rd_data == 8'h77, "R7 latest word", rd_data, 8'h77);
    step(0, 0, 1, 0, 3'b000); idle();

    // R11 underflow
    step(0, 0, 1, 0, 3'b000);
    chk(flags[2] == 1, "R11 underflow", flags[2], 1);
    chk(rd_valid == 0, "R11 no data", rd_valid, 0);

    // R12 clear
    step(0, 0, 0, 1, 3'b001);
    chk(flags == 3'b100, "R12 partial clear", flags, 3'b100);
    step(0, 0, 0, 1, 3'b111);
    chk(flags == 3'b000, "R12 full clear", flags, 0);

    // R9 premature frame sync
    send(8'hC3, 3, 1);
    chk(flags[1] == 1, "R9 sync flag", flags[1], 1);
    idle();
    chk(rd_data == 8'hC3, "R9 word intact", rd_data, 8'hC3);
    step(0, 0, 1, 1, 3'b111); idle();

    // R10 back-to-back frames
    send(8'h96, W-1, 1);
    send(8'h69, -1, 0);
    idle();
    chk(flags[1] == 0, "R10 no sync flag", flags[1], 0);
    chk(rd_data == 8'h96, "R10 first word", rd_data, 8'h96);
    step(0, 0, 1, 0, 3'b000); idle();
    chk(rd_data == 8'h69, "R10 second word", rd_data, 8'h69);
    step(0, 0, 1, 0, 3'b000); idle();

    // R13 interrupt gating
    irq_en = 3'b010;
    send(8'h11, 2, 1);
    chk(irq == 1, "R13 enabled irq", irq, 1);
    irq_en = 3'b101;
    #1 chk(irq == 0, "R13 masked irq", irq, 0);
    step(0, 0, 1, 1, 3'b111); idle();

    // random phase, checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 64 == 0) irq_en = 3'($urandom);
      step(($urandom % 10) == 0, 1'($urandom), ($urandom % 5) == 0,
           ($urandom % 16) == 0, 3'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule